// File: doc/BRIEF.md
# NOR Flash Command Cycle Decoder

This block watches the bus writes aimed at a parallel NOR flash and works out which command sequence the host is issuing. A command is accepted only after a two-write unlock: each write is checked against the expected data byte and an unlock word address. The block moves between read-array, autoselect (identifier), CFI query, program and erase modes. It reports the mode on a registered output and issues one-cycle requests to the array (program) or to an erase scheduler (chip or sector erase).

On the read side, the block tells the data path what to return for the current read address. The choices are array data, an identifier word, zero, a CFI table byte at a given index, or the status word. The array, the CFI table contents and all erase timing sit outside the block.

A scheduler feeds back four signals:
- `erase_done_i`: the erase has finished.
- `erase_window_i`: additional sector-erase commands are still accepted.
- `erase_suspended_i`: an erase is suspended.
- `sector_erasing_i`: the current write address lies in a sector that is being erased.

The array presents the current contents of the written word on `arr_data_i`.

Top module: `nor_cmd_decoder`

## Requirements
- R1: Addresses are turned into word addresses by a right shift that `bus_width_i` selects: 0 gives no shift, 1 gives one bit, 2 or 3 give two bits. Only the low 11 bits of the word address are compared with the unlock addresses. An unlock is 0xAA at unlock address 0, then 0x55 at unlock address 1. After a third write to unlock address 0, the mode becomes autoselect (0x90), program (0xA0) or erase setup (0x80).
- R2: Every write is decoded on the low 8 data bits. A wrong data byte or a wrong address in any unlock or command cycle returns the decoder to read mode and clears bypass. So does a command byte other than 0x20, 0x80, 0x90 or 0xA0.
- R3: In autoselect, reads give `rd_sel_o` = 1 (identifier) with `rd_id_o` set as follows:
  - word 0 gives id0, and word 1 gives id1;
  - word 0x0E gives id2, and word 0x0F gives id3, unless that identifier is all ones, in which case they read array (`rd_sel_o` = 0);
  - word 2 gives zero (`rd_sel_o` = 2);
  - any other word reads array.
- R4: Writing 0x98 to word 0x55 from read mode (or from the first erase-unlock cycle) enters CFI query. In CFI query, reads give `rd_sel_o` = 3 with `rd_idx_o` set to the low 8 bits of the word address when that is below CFI_LEN, and zero (`rd_sel_o` = 2) otherwise.
- R5: Writing 0x98 to word 0x55 from autoselect enters a CFI query from which 0xF0 returns to autoselect. Any other write during either CFI query returns to read mode.
- R6: The data byte 0xF0 returns the decoder to read mode and clears bypass from every state except three: the program data cycle, where 0xF0 is program data, and chip or sector erase, where it is ignored.
- R7: The write after the program command produces `prog_stb_o` for one cycle, one cycle later, with `prog_data_o` = written data AND `arr_data_i` and `req_addr_o` = the write's byte address. The mode then leaves program.
- R8: Command 0x20 turns on bypass. With bypass on, the command cycle skips its address check, and a finished program returns directly to the command cycle. In autoselect with bypass on, 0x00 returns to read mode with bypass off.
- R9: A second unlock after 0x80, then 0x10 at unlock address 0, pulses `chip_erase_o` and enters erase mode. Erase mode ignores writes until `erase_done_i`, which returns to the command cycle if bypass is on and to read mode otherwise.
- R10: After the second unlock, 0x30 at any address pulses `sect_erase_o` with `req_addr_o` set to that address. While `erase_window_i` is high in sector erase, each further 0x30 issues another request. Other writes, and writes after the window closes, are ignored.
- R11: While `erase_suspended_i` is high, two things are dropped:
  - a program data write with `sector_erasing_i` high (no strobe, same next state);
  - the erase command cycle, which returns to read mode.
- R12: `mode_o` is registered: 0 read, 1 autoselect, 2 CFI, 3 program, 4 erase. It changes on the clock edge that takes the write. `rd_sel_o` is 4 (status) in program and erase modes, and 0 (array) in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | DATA_W | Write data; low byte is the command |
| arr_data_i | input | DATA_W | Current array word at wr_addr_i |
| rd_addr_i | input | ADDR_W | Read byte address |
| bus_width_i | input | 2 | Bus width code: 0 byte, 1 half-word, 2 or 3 word |
| unlock0_i | input | 11 | Unlock word address 0 |
| unlock1_i | input | 11 | Unlock word address 1 |
| id0_i | input | ID_W | Identifier word 0 |
| id1_i | input | ID_W | Identifier word 1 |
| id2_i | input | ID_W | Identifier word 0x0E |
| id3_i | input | ID_W | Identifier word 0x0F |
| erase_done_i | input | 1 | Scheduler: erase finished |
| erase_window_i | input | 1 | Scheduler: extra sector commands still accepted |
| erase_suspended_i | input | 1 | Scheduler: erase suspended |
| sector_erasing_i | input | 1 | Scheduler: write address is in an erasing sector |
| mode_o | output | 3 | Registered mode |
| prog_stb_o | output | 1 | Program request |
| prog_data_o | output | DATA_W | Data to store (already combined with array word) |
| req_addr_o | output | ADDR_W | Address of program or sector erase request |
| chip_erase_o | output | 1 | Chip erase request |
| sect_erase_o | output | 1 | Sector erase request |
| rd_sel_o | output | 3 | Read mux select: 0 array, 1 identifier, 2 zero, 3 CFI, 4 status |
| rd_id_o | output | ID_W | Identifier value for select 1 |
| rd_idx_o | output | 8 | CFI table index for select 3 |

## Verification
The bench builds the block with ADDR_W 20, DATA_W 16, ID_W 16 and CFI_LEN 77. With a 20-bit address, a write can set word-address bits above bit 10, so the bench can show that the 11-bit compare ignores them. A CFI_LEN of 77 puts the table end at word 0x4D, so both sides of the boundary can be read through the 8-bit index. The bench drives `bus_width_i` at 0, 1 and 2 and keeps the unlock addresses the same, so each shift setting has to reach the same compare. id3 is set to all ones so that the array fallback in autoselect is visible.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_AUTO  = 3'd1,
    MODE_CFI   = 3'd2,
    MODE_PROG  = 3'd3,
    MODE_ERASE = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    SEL_ARRAY  = 3'd0,
    SEL_ID     = 3'd1,
    SEL_ZERO   = 3'd2,
    SEL_CFI    = 3'd3,
    SEL_STATUS = 3'd4
  } rsel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLK1, ST_CMD, ST_AUTO, ST_PROG,
    ST_E_UNLK0, ST_E_UNLK1, ST_E_CMD, ST_CHIP, ST_SECT,
    ST_CFI, ST_CFI_AUTO
  } state_e;

  localparam int UA_W = 11;

  localparam logic [7:0] C_UNLK_A  = 8'hAA;
  localparam logic [7:0] C_UNLK_B  = 8'h55;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_AUTO    = 8'h90;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECT    = 8'h30;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_BYP_EXT = 8'h00;
  localparam logic [UA_W-1:0] QUERY_WORD = 11'h055;

  function automatic mode_e mode_of(state_e s);
    case (s)
      ST_AUTO:             return MODE_AUTO;
      ST_CFI, ST_CFI_AUTO: return MODE_CFI;
      ST_PROG:             return MODE_PROG;
      ST_CHIP, ST_SECT:    return MODE_ERASE;
      default:             return MODE_READ;
    endcase
  endfunction
endpackage

// File: rtl/nor_word_addr.sv
module nor_word_addr #(
  parameter int ADDR_W = 20,
  parameter int OUT_W  = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bw_i,
  output logic [OUT_W-1:0]  word_o
);
  logic [ADDR_W-1:0] sh;

  always_comb begin
    case (bw_i)
      2'd0:    sh = addr_i;
      2'd1:    sh = addr_i >> 1;
      default: sh = addr_i >> 2;
    endcase
  end

  assign word_o = sh[OUT_W-1:0];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [UA_W-1:0]   wr_word_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic [UA_W-1:0]   unlock0_i,
  input  logic [UA_W-1:0]   unlock1_i,
  input  logic              erase_done_i,
  input  logic              erase_window_i,
  input  logic              erase_suspended_i,
  input  logic              sector_erasing_i,
  output state_e            state_o,
  output logic [2:0]        mode_o,
  output logic              prog_stb_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              chip_erase_o,
  output logic              sect_erase_o
);
  state_e state_q, state_d;
  logic   byp_q, byp_d;
  logic   do_prog, do_chip, do_sect, go_rst;
  logic   hit0, hit1, q_hit;
  logic [7:0] cmd;
  mode_e  mode_q;

  assign cmd   = wr_data_i[7:0];
  assign hit0  = (wr_word_i == unlock0_i);
  assign hit1  = (wr_word_i == unlock1_i);
  assign q_hit = (wr_word_i == QUERY_WORD) && (cmd == C_QUERY);

  always_comb begin
    state_d = state_q;
    byp_d   = byp_q;
    do_prog = 1'b0;
    do_chip = 1'b0;
    do_sect = 1'b0;
    go_rst  = 1'b0;
    if (erase_done_i && (state_q == ST_CHIP || state_q == ST_SECT)) begin
      state_d = byp_q ? ST_CMD : ST_IDLE;
    end else if (wr_en_i) begin
      if (cmd == C_RESET && state_q != ST_PROG &&
          state_q != ST_CHIP && state_q != ST_SECT) begin
        if (state_q == ST_CFI_AUTO) state_d = ST_AUTO;
        else                        go_rst  = 1'b1;
      end else begin
        case (state_q)
          ST_IDLE, ST_E_UNLK0: begin
            if (q_hit)                         state_d = ST_CFI;
            else if (hit0 && cmd == C_UNLK_A)  state_d = (state_q == ST_IDLE) ? ST_UNLK1 : ST_E_UNLK1;
            else                               go_rst  = 1'b1;
          end
          ST_UNLK1, ST_E_UNLK1: begin
            if (hit1 && cmd == C_UNLK_B) state_d = (state_q == ST_UNLK1) ? ST_CMD : ST_E_CMD;
            else                         go_rst  = 1'b1;
          end
          ST_CMD: begin
            if (!byp_q && !hit0) go_rst = 1'b1;
            else begin
              case (cmd)
                C_BYPASS: byp_d   = 1'b1;
                C_ERASE:  state_d = ST_E_UNLK0;
                C_AUTO:   state_d = ST_AUTO;
                C_PROG:   state_d = ST_PROG;
                default:  go_rst  = 1'b1;
              endcase
            end
          end
          ST_AUTO: begin
            if (byp_q && cmd == C_BYP_EXT) go_rst  = 1'b1;
            else if (q_hit)                state_d = ST_CFI_AUTO;
            else                           go_rst  = 1'b1;
          end
          ST_PROG: begin
            do_prog = !(erase_suspended_i && sector_erasing_i);
            state_d = byp_q ? ST_CMD : ST_IDLE;
          end
          ST_E_CMD: begin
            if (erase_suspended_i)              go_rst = 1'b1;
            else if (cmd == C_CHIP && hit0) begin
              state_d = ST_CHIP;
              do_chip = 1'b1;
            end else if (cmd == C_SECT) begin
              state_d = ST_SECT;
              do_sect = 1'b1;
            end else                            go_rst = 1'b1;
          end
          ST_CHIP: ;
          ST_SECT: do_sect = erase_window_i && (cmd == C_SECT);
          default: go_rst = 1'b1;
        endcase
      end
    end
    if (go_rst) begin
      state_d = ST_IDLE;
      byp_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      byp_q        <= 1'b0;
      mode_q       <= MODE_READ;
      prog_stb_o   <= 1'b0;
      chip_erase_o <= 1'b0;
      sect_erase_o <= 1'b0;
      prog_data_o  <= '0;
      req_addr_o   <= '0;
    end else begin
      state_q      <= state_d;
      byp_q        <= byp_d;
      mode_q       <= mode_of(state_d);
      prog_stb_o   <= do_prog;
      chip_erase_o <= do_chip;
      sect_erase_o <= do_sect;
      if (do_prog)           prog_data_o <= wr_data_i & arr_data_i;
      if (do_prog || do_sect) req_addr_o <= wr_addr_i;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/nor_rd_mux.sv
module nor_rd_mux
  import nor_cmd_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int CFI_LEN = 77
) (
  input  state_e          state_i,
  input  logic [7:0]      rd_word_i,
  input  logic [ID_W-1:0] id0_i,
  input  logic [ID_W-1:0] id1_i,
  input  logic [ID_W-1:0] id2_i,
  input  logic [ID_W-1:0] id3_i,
  output logic [2:0]      rd_sel_o,
  output logic [ID_W-1:0] rd_id_o,
  output logic [7:0]      rd_idx_o
);
  localparam logic [7:0] CFI_END = 8'(CFI_LEN);
  rsel_e sel;

  always_comb begin
    sel     = SEL_ARRAY;
    rd_id_o = '0;
    case (state_i)
      ST_AUTO: begin
        case (rd_word_i)
          8'h00: begin sel = SEL_ID; rd_id_o = id0_i; end
          8'h01: begin sel = SEL_ID; rd_id_o = id1_i; end
          8'h02: sel = SEL_ZERO;
          8'h0E: if (~&id2_i) begin sel = SEL_ID; rd_id_o = id2_i; end
          8'h0F: if (~&id3_i) begin sel = SEL_ID; rd_id_o = id3_i; end
          default: sel = SEL_ARRAY;
        endcase
      end
      ST_CFI, ST_CFI_AUTO: sel = (rd_word_i < CFI_END) ? SEL_CFI : SEL_ZERO;
      ST_PROG, ST_CHIP, ST_SECT: sel = SEL_STATUS;
      default: sel = SEL_ARRAY;
    endcase
  end

  assign rd_sel_o = sel;
  assign rd_idx_o = rd_word_i;
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int ID_W    = 16,
  parameter int CFI_LEN = 77
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [1:0]        bus_width_i,
  input  logic [10:0]       unlock0_i,
  input  logic [10:0]       unlock1_i,
  input  logic [ID_W-1:0]   id0_i,
  input  logic [ID_W-1:0]   id1_i,
  input  logic [ID_W-1:0]   id2_i,
  input  logic [ID_W-1:0]   id3_i,
  input  logic              erase_done_i,
  input  logic              erase_window_i,
  input  logic              erase_suspended_i,
  input  logic              sector_erasing_i,
  output logic [2:0]        mode_o,
  output logic              prog_stb_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              chip_erase_o,
  output logic              sect_erase_o,
  output logic [2:0]        rd_sel_o,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [7:0]        rd_idx_o
);
  logic [UA_W-1:0] wr_word;
  logic [7:0]      rd_word;
  state_e          state;

  nor_word_addr #(.ADDR_W(ADDR_W), .OUT_W(UA_W)) u_wr_addr (
    .addr_i(wr_addr_i), .bw_i(bus_width_i), .word_o(wr_word)
  );

  nor_word_addr #(.ADDR_W(ADDR_W), .OUT_W(8)) u_rd_addr (
    .addr_i(rd_addr_i), .bw_i(bus_width_i), .word_o(rd_word)
  );

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_word_i(wr_word), .wr_addr_i, .wr_data_i, .arr_data_i,
    .unlock0_i, .unlock1_i,
    .erase_done_i, .erase_window_i, .erase_suspended_i, .sector_erasing_i,
    .state_o(state), .mode_o, .prog_stb_o, .prog_data_o, .req_addr_o,
    .chip_erase_o, .sect_erase_o
  );

  nor_rd_mux #(.ID_W(ID_W), .CFI_LEN(CFI_LEN)) u_rd_mux (
    .state_i(state), .rd_word_i(rd_word),
    .id0_i, .id1_i, .id2_i, .id3_i,
    .rd_sel_o, .rd_id_o, .rd_idx_o
  );
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic              erase_done_i,
  input logic [2:0]        mode_o,
  input logic              prog_stb_o,
  input logic [DATA_W-1:0] prog_data_o,
  input logic              chip_erase_o,
  input logic              sect_erase_o,
  input logic [2:0]        rd_sel_o
);
  p_one_request_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_stb_o, chip_erase_o, sect_erase_o}));

  p_prog_from_prog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stb_o |-> $past(mode_o) == MODE_PROG);

  p_prog_and_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stb_o |-> (prog_data_o & ~$past(arr_data_i)) == '0);

  p_chip_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> mode_o == MODE_ERASE);

  p_sect_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_erase_o |-> mode_o == MODE_ERASE);

  p_erase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_ERASE && !erase_done_i) |=> mode_o == MODE_ERASE);

  p_auto_reset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[7:0] == C_RESET && mode_o == MODE_AUTO) |=> mode_o == MODE_READ);

  p_status_sel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_PROG || mode_o == MODE_ERASE) |-> rd_sel_o == SEL_STATUS);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .arr_data_i(arr_data_i), .erase_done_i(erase_done_i), .mode_o(mode_o),
  .prog_stb_o(prog_stb_o), .prog_data_o(prog_data_o), .chip_erase_o(chip_erase_o),
  .sect_erase_o(sect_erase_o), .rd_sel_o(rd_sel_o)
);

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
  localparam int AW = 20, DW = 16, IW = 16;
  localparam logic [AW-1:0] UA0 = 20'hAAA, UA1 = 20'h554;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, done = 0, win = 0, susp = 0, sec_er = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, arr = 16'hFFFF;
  logic [1:0] bw = 2'd1;
  logic [10:0] ua0 = 11'h555, ua1 = 11'h2AA;
  logic [IW-1:0] id0 = 16'h0001, id1 = 16'h227E, id2 = 16'h2221, id3 = 16'hFFFF;
  logic [2:0] mode, rsel;
  logic pstb, ce, se;
  logic [DW-1:0] pdata;
  logic [AW-1:0] raddr;
  logic [IW-1:0] rid;
  logic [7:0] ridx;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nor_cmd_decoder u_nor_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .arr_data_i(arr), .rd_addr_i(rd_addr), .bus_width_i(bw),
    .unlock0_i(ua0), .unlock1_i(ua1), .id0_i(id0), .id1_i(id1), .id2_i(id2),
    .id3_i(id3), .erase_done_i(done), .erase_window_i(win),
    .erase_suspended_i(susp), .sector_erasing_i(sec_er), .mode_o(mode),
    .prog_stb_o(pstb), .prog_data_o(pdata), .req_addr_o(raddr),
    .chip_erase_o(ce), .sect_erase_o(se), .rd_sel_o(rsel), .rd_id_o(rid),
    .rd_idx_o(ridx)
  );

  // reference model state
  localparam int M_RD = 0, M_U1 = 1, M_CM = 2, M_AS = 3, M_PG = 4, M_EU0 = 5,
                 M_EU1 = 6, M_EC = 7, M_CE = 8, M_SE = 9, M_QR = 10, M_QA = 11;
  int m_st = M_RD;
  bit m_byp = 0;
  bit e_pstb, e_ce, e_se;
  logic [DW-1:0] e_pdata;
  logic [AW-1:0] e_addr;

  function automatic int exp_mode(int s);
    if (s == M_AS) return 1;
    if (s == M_QR || s == M_QA) return 2;
    if (s == M_PG) return 3;
    if (s == M_CE || s == M_SE) return 4;
    return 0;
  endfunction

  task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int sh;
    logic [10:0] w;
    logic [7:0] c;
    bit rs;
    sh = (bw == 0) ? 0 : (bw == 1) ? 1 : 2;
    w = 11'(a >> sh);
    c = d[7:0];
    rs = 0;
    e_pstb = 0; e_ce = 0; e_se = 0;
    if (c == 8'hF0 && m_st != M_PG && m_st != M_CE && m_st != M_SE) begin
      if (m_st == M_QA) m_st = M_AS; else rs = 1;
    end else if (m_st == M_RD || m_st == M_EU0) begin
      if (w == 11'h055 && c == 8'h98) m_st = M_QR;
      else if (w == ua0 && c == 8'hAA) m_st = (m_st == M_RD) ? M_U1 : M_EU1;
      else rs = 1;
    end else if (m_st == M_U1 || m_st == M_EU1) begin
      if (w == ua1 && c == 8'h55) m_st = (m_st == M_U1) ? M_CM : M_EC;
      else rs = 1;
    end else if (m_st == M_CM) begin
      if (!m_byp && w != ua0) rs = 1;
      else if (c == 8'h20) m_byp = 1;
      else if (c == 8'h80) m_st = M_EU0;
      else if (c == 8'h90) m_st = M_AS;
      else if (c == 8'hA0) m_st = M_PG;
      else rs = 1;
    end else if (m_st == M_AS) begin
      if (m_byp && c == 8'h00) rs = 1;
      else if (w == 11'h055 && c == 8'h98) m_st = M_QA;
      else rs = 1;
    end else if (m_st == M_PG) begin
      if (!(susp && sec_er)) begin e_pstb = 1; e_pdata = d & arr; e_addr = a; end
      m_st = m_byp ? M_CM : M_RD;
    end else if (m_st == M_EC) begin
      if (susp) rs = 1;
      else if (c == 8'h10 && w == ua0) begin m_st = M_CE; e_ce = 1; end
      else if (c == 8'h30) begin m_st = M_SE; e_se = 1; e_addr = a; end
      else rs = 1;
    end else if (m_st == M_SE) begin
      if (win && c == 8'h30) begin e_se = 1; e_addr = a; end
    end else if (m_st != M_CE) rs = 1;
    if (rs) begin m_st = M_RD; m_byp = 0; end
  endtask

  task automatic check_outs(input string req);
    check_eq(req, "mode", 32'(mode), 32'(exp_mode(m_st)));
    check_eq(req, "prog_stb", 32'(pstb), 32'(e_pstb));
    check_eq(req, "chip_erase", 32'(ce), 32'(e_ce));
    check_eq(req, "sect_erase", 32'(se), 32'(e_se));
    if (e_pstb) begin
      check_eq(req, "prog_data", 32'(pdata), 32'(e_pdata));
      check_eq(req, "prog_addr", 32'(raddr), 32'(e_addr));
    end
    if (e_se) check_eq(req, "erase_addr", 32'(raddr), 32'(e_addr));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 0;
    check_outs(req);
  endtask

  task automatic finish_erase(input string req);
    @(negedge clk);
    done = 1;
    e_pstb = 0; e_ce = 0; e_se = 0;
    if (m_st == M_CE || m_st == M_SE) m_st = m_byp ? M_CM : M_RD;
    @(negedge clk);
    done = 0;
    check_outs(req);
  endtask

  task automatic unlock(input string req);
    wr(UA0, 16'h00AA, req);
    wr(UA1, 16'h0055, req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input int sel, input logic [IW-1:0] v, input logic [7:0] idx, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    check_eq(req, "rd_sel", 32'(rsel), 32'(sel));
    if (sel == 1) check_eq(req, "rd_id", 32'(rid), 32'(v));
    if (sel == 3) check_eq(req, "rd_idx", 32'(ridx), 32'(idx));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    e_pstb = 0; e_ce = 0; e_se = 0;
    @(negedge clk);
    check_outs("R12");
    rd(20'h0, 0, 0, 0, "R12");

    // autoselect and identifier reads
    unlock("R1"); wr(UA0, 16'h0090, "R1");
    rd(20'h00, 1, id0, 0, "R3");
    rd(20'h02, 1, id1, 0, "R3");
    rd(20'h04, 2, 0, 0, "R3");
    rd(20'h1C, 1, id2, 0, "R3");
    rd(20'h1E, 0, 0, 0, "R3");
    rd(20'h10, 0, 0, 0, "R3");
    wr(20'h0, 16'h00F0, "R6");

    // upper word bits ignored by the 11-bit compare
    wr(20'h1AAA, 16'h00AA, "R1"); wr(20'h1554, 16'h0055, "R1"); wr(20'h1AAA, 16'h0090, "R1");
    wr(20'h0, 16'h00F0, "R6");

    // broken sequences
    wr(UA0, 16'h00AA, "R2"); wr(UA1, 16'h0056, "R2"); wr(UA0, 16'h0090, "R2");
    unlock("R2"); wr(UA0, 16'h0033, "R2"); wr(UA0, 16'h0090, "R2");
    unlock("R2"); wr(20'h10, 16'h0090, "R2");

    // CFI from read mode
    wr(20'hAA, 16'h0098, "R4");
    rd(20'h20, 3, 0, 8'h10, "R4");
    rd(20'h98, 3, 0, 8'h4C, "R4");
    rd(20'h9A, 2, 0, 0, "R4");
    wr(20'h0, 16'h0012, "R5");

    // CFI nested in autoselect
    unlock("R5"); wr(UA0, 16'h0090, "R5"); wr(20'hAA, 16'h0098, "R5");
    wr(20'h0, 16'h00F0, "R5");
    rd(20'h00, 1, id0, 0, "R5");
    wr(20'h0, 16'h00F0, "R6");

    // program
    unlock("R7"); wr(UA0, 16'h00A0, "R7");
    rd(20'h0, 4, 0, 0, "R12");
    arr = 16'h0F0F; wr(20'h100, 16'h1234, "R7");
    arr = 16'hFFFF;
    unlock("R6"); wr(UA0, 16'h00A0, "R6"); wr(20'h200, 16'h00F0, "R6");

    // bypass
    unlock("R8"); wr(UA0, 16'h0020, "R8");
    wr(20'h300, 16'h00A0, "R8"); arr = 16'hF0FF; wr(20'h302, 16'hBEEF, "R8");
    arr = 16'hFFFF;
    wr(20'h0, 16'h00A0, "R8"); wr(20'h4, 16'h5555, "R8");
    wr(20'h6, 16'h0090, "R8"); wr(20'h0, 16'h0000, "R8");
    wr(20'h300, 16'h00A0, "R8"); wr(20'h302, 16'h1111, "R8");

    // chip erase
    unlock("R9"); wr(UA0, 16'h0080, "R9"); unlock("R9"); wr(UA0, 16'h0010, "R9");
    rd(20'h0, 4, 0, 0, "R12");
    wr(20'h0, 16'h00F0, "R6"); wr(20'h0, 16'h0012, "R9");
    finish_erase("R9");
    unlock("R9"); wr(UA0, 16'h0080, "R9"); unlock("R9"); wr(20'h10, 16'h0010, "R9");

    // sector erase
    win = 1;
    unlock("R10"); wr(UA0, 16'h0080, "R10"); unlock("R10");
    wr(20'h8000, 16'h0030, "R10"); wr(20'h9000, 16'h0030, "R10");
    wr(20'h9000, 16'h0055, "R10");
    win = 0; wr(20'hA000, 16'h0030, "R10");
    finish_erase("R10");

    // erase suspend
    susp = 1; sec_er = 1;
    unlock("R11"); wr(UA0, 16'h0020, "R11");
    wr(20'h0, 16'h00A0, "R11"); wr(20'h8000, 16'h1234, "R11");
    sec_er = 0;
    wr(20'h0, 16'h00A0, "R11"); wr(20'h40, 16'h00FF, "R11");
    wr(20'h0, 16'h0090, "R11"); wr(20'h0, 16'h0000, "R11");
    unlock("R11"); wr(UA0, 16'h0080, "R11"); unlock("R11"); wr(UA0, 16'h0010, "R11");
    susp = 0;

    // other bus widths
    bw = 2'd0;
    wr(20'h555, 16'h00AA, "R1"); wr(20'h2AA, 16'h0055, "R1"); wr(20'h555, 16'h0090, "R1");
    rd(20'h1, 1, id1, 0, "R1");
    wr(20'h0, 16'h00F0, "R1");
    bw = 2'd2;
    wr(20'h1554, 16'h00AA, "R1"); wr(20'hAA8, 16'h0055, "R1"); wr(20'h1554, 16'h0090, "R1");
    rd(20'h4, 1, id1, 0, "R1");
    wr(20'h0, 16'h00F0, "R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule